// File: doc/BRIEF.md
# Address-Windowed Bus Access Counter

This block sits in line between a processor's data master and a memory slave on a memory-mapped bus that stalls with an active-high waitrequest. Every request field travels downstream and every response field travels upstream with no register in the path, so the memory behaves as though it were wired directly to the processor. The block adds no cycles and changes no timing.

While the traffic passes through, the block watches for accepted transfers. A transfer is accepted in a cycle where read or write is high and the memory is not stalling. When counting is enabled, each accepted transfer goes into one of two tallies. It is a hit when its byte address lies inside a window that software programs. Otherwise it is a miss. This lets software measure only the accesses to one data region. Accesses from stacks, interrupt handlers or other regions that share the same master do not inflate the hit count.

A small control port with a three-bit word address handles the settings. Through it software clears the tallies, turns counting on or off, sets the window bounds and reads both counts back. This port never stalls.

Top module: `bus_window_tap`

## Requirements
- R1: Address, read, write, write data, byte enables, burst count and burst begin appear on the downstream outputs in the same cycle they are presented upstream. Read data, read-data-valid and waitrequest return upstream in the same cycle, with their values unchanged.
- R2: A transfer is accepted in a cycle where `up_read` or `up_write` is 1 and `dn_waitreq` is 0. A request held through N stalled cycles adds exactly one to a count.
- R3: Bit 1 of a write to control word 0 is the enable. It takes effect from the cycle after the write. While it is 0, neither count changes.
- R4: Bit 0 of a write to control word 0 is the clear. While the last value written there is 1, both counts are held at zero from the cycle after the write. An accepted transfer in such a cycle does not count, because clear wins over increment.
- R5: Control word 1 holds the inclusive lower byte-address bound and control word 2 holds the inclusive upper bound. An enabled accepted transfer with lower <= address <= upper adds one to the hit count, and both exact bounds count as hits.
- R6: An enabled accepted transfer whose address is outside the window adds one to a separate miss count. When lower > upper, every such transfer is a miss.
- R7: A control read presents its data on `cfg_rdata` after the clock edge at which `cfg_read_n` is low. Word 0 returns the hit count, word 1 the lower bound, word 2 the upper bound and word 3 the miss count. Words 4 to 7 return zero. `cfg_waitreq` is always 0.
- R8: Both counts saturate at all ones (2^CNT_W-1) and do not wrap.
- R9: After the synchronous active-high `rst`, both counts are zero, counting is disabled, the clear is off, the lower bound is 0 and the upper bound is all ones.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Single clock |
| rst | input | 1 | Synchronous active-high reset |
| up_addr | input | ADDR_W | Byte address from the processor |
| up_read | input | 1 | Read request from the processor |
| up_write | input | 1 | Write request from the processor |
| up_wdata | input | DATA_W | Write data from the processor |
| up_be | input | DATA_W/8 | Byte enables from the processor |
| up_burstcnt | input | BURST_W | Burst count from the processor |
| up_burstbegin | input | 1 | Burst start marker from the processor |
| up_rdata | output | DATA_W | Read data returned to the processor |
| up_rvalid | output | 1 | Read-data-valid returned to the processor |
| up_waitreq | output | 1 | Stall returned to the processor |
| dn_addr | output | ADDR_W | Byte address to memory |
| dn_read | output | 1 | Read request to memory |
| dn_write | output | 1 | Write request to memory |
| dn_wdata | output | DATA_W | Write data to memory |
| dn_be | output | DATA_W/8 | Byte enables to memory |
| dn_burstcnt | output | BURST_W | Burst count to memory |
| dn_burstbegin | output | 1 | Burst start marker to memory |
| dn_rdata | input | DATA_W | Read data from memory |
| dn_rvalid | input | 1 | Read-data-valid from memory |
| dn_waitreq | input | 1 | Stall from memory, active high |
| cfg_addr | input | 3 | Control word address |
| cfg_wdata | input | DATA_W | Control write data |
| cfg_write_n | input | 1 | Control write strobe, active low |
| cfg_read_n | input | 1 | Control read strobe, active low |
| cfg_rdata | output | DATA_W | Registered control read data |
| cfg_waitreq | output | 1 | Control stall, always 0 |

## Verification
The assertions assume that `dn_waitreq` and the request strobes are stable, known values at each rising edge. They also assume that reset is held for at least one edge before traffic starts. The stall and disable properties depend on the counters changing only at edges, based on the previous cycle's acceptance.

The bench respects these assumptions. It drives every input at the falling edge and holds reset for several cycles first. It changes settings only through complete control writes between transfers. The stimulus sweeps every address of an 8-bit space with stall lengths of zero to two cycles, which covers all positions relative to the window.

// File: rtl/bwt_pkg.sv
package bwt_pkg;

   localparam int CFG_AW = 3;

   typedef enum logic [CFG_AW-1:0] {
      REG_CTRL = 3'd0,
      REG_LO   = 3'd1,
      REG_HI   = 3'd2,
      REG_MISS = 3'd3
   } bwt_reg_e;

   localparam int CTRL_CLR_BIT = 0;
   localparam int CTRL_EN_BIT  = 1;

endpackage

// File: rtl/bwt_passthru.sv
module bwt_passthru #(
   parameter int ADDR_W  = 32,
   parameter int DATA_W  = 32,
   parameter int BURST_W = 4
) (
   input  logic [ADDR_W-1:0]   up_addr,
   input  logic                up_read,
   input  logic                up_write,
   input  logic [DATA_W-1:0]   up_wdata,
   input  logic [DATA_W/8-1:0] up_be,
   input  logic [BURST_W-1:0]  up_burstcnt,
   input  logic                up_burstbegin,
   output logic [DATA_W-1:0]   up_rdata,
   output logic                up_rvalid,
   output logic                up_waitreq,
   output logic [ADDR_W-1:0]   dn_addr,
   output logic                dn_read,
   output logic                dn_write,
   output logic [DATA_W-1:0]   dn_wdata,
   output logic [DATA_W/8-1:0] dn_be,
   output logic [BURST_W-1:0]  dn_burstcnt,
   output logic                dn_burstbegin,
   input  logic [DATA_W-1:0]   dn_rdata,
   input  logic                dn_rvalid,
   input  logic                dn_waitreq,
   output logic                accept
);

   // Request side: straight wires, no added latency.
   assign dn_addr       = up_addr;
   assign dn_read       = up_read;
   assign dn_write      = up_write;
   assign dn_wdata      = up_wdata;
   assign dn_be         = up_be;
   assign dn_burstcnt   = up_burstcnt;
   assign dn_burstbegin = up_burstbegin;

   // Response side.
   assign up_rdata   = dn_rdata;
   assign up_rvalid  = dn_rvalid;
   assign up_waitreq = dn_waitreq;

   // A cycle with a request that memory does not stall completes a transfer.
   assign accept = (up_read | up_write) & ~dn_waitreq;

endmodule

// File: rtl/bwt_window.sv
module bwt_window #(
   parameter int ADDR_W = 32
) (
   input  logic [ADDR_W-1:0] addr,
   input  logic [ADDR_W-1:0] lo,
   input  logic [ADDR_W-1:0] hi,
   output logic              hit
);

   logic above_lo;
   logic below_hi;

   // Inclusive byte-address compare; empty window when lo > hi.
   assign above_lo = (addr >= lo);
   assign below_hi = (addr <= hi);
   assign hit      = above_lo & below_hi;

endmodule

// File: rtl/bwt_sat_counter.sv
module bwt_sat_counter #(
   parameter int W        = 32,
   parameter bit SATURATE = 1'b1
) (
   input  logic         clk,
   input  logic         rst,
   input  logic         clr,
   input  logic         inc,
   output logic [W-1:0] cnt
);

   localparam logic [W-1:0] MAXV = '1;

   logic [W-1:0] cnt_q;

   initial begin
      assert (W >= 2 && W <= 64)
         else $fatal(1, "bwt_sat_counter: W out of range");
   end

   generate
      if (SATURATE) begin : g_sat
         always_ff @(posedge clk) begin
            if (rst || clr) begin
               cnt_q <= '0;
            end else if (inc && (cnt_q != MAXV)) begin
               cnt_q <= cnt_q + 1'b1;
            end
         end

         // R8: a full counter stays full until cleared
         a_r8_hold_max: assert property (@(posedge clk) disable iff (rst)
            (cnt_q == MAXV && !clr) |=> (cnt_q == MAXV));
      end else begin : g_wrap
         always_ff @(posedge clk) begin
            if (rst || clr) begin
               cnt_q <= '0;
            end else if (inc) begin
               cnt_q <= cnt_q + 1'b1;
            end
         end
      end
   endgenerate

   assign cnt = cnt_q;

   // R2: one step at most per cycle
   a_r2_single_step: assert property (@(posedge clk) disable iff (rst)
      !clr |=> (cnt_q == $past(cnt_q)) || (cnt_q == $past(cnt_q) + 1'b1));

   // R4: clear wins over any increment
   a_r4_clear_zero: assert property (@(posedge clk) disable iff (rst)
      clr |=> (cnt_q == '0));

endmodule

// File: rtl/bwt_ctrl.sv
module bwt_ctrl
   import bwt_pkg::*;
#(
   parameter int ADDR_W = 32,
   parameter int DATA_W = 32,
   parameter int CNT_W  = 32
) (
   input  logic              clk,
   input  logic              rst,
   input  logic [CFG_AW-1:0] cfg_addr,
   input  logic [DATA_W-1:0] cfg_wdata,
   input  logic              cfg_write_n,
   input  logic              cfg_read_n,
   output logic [DATA_W-1:0] cfg_rdata,
   output logic              cfg_waitreq,
   input  logic [CNT_W-1:0]  hit_cnt,
   input  logic [CNT_W-1:0]  miss_cnt,
   output logic              en,
   output logic              clr,
   output logic [ADDR_W-1:0] lo,
   output logic [ADDR_W-1:0] hi
);

   logic              en_q;
   logic              clr_q;
   logic [ADDR_W-1:0] lo_q;
   logic [ADDR_W-1:0] hi_q;
   logic [DATA_W-1:0] rdata_q;
   logic [DATA_W-1:0] rd_mux;
   logic              wr_stb;
   logic              rd_stb;
   logic              unused_wdata;

   assign wr_stb       = ~cfg_write_n;
   assign rd_stb       = ~cfg_read_n;
   assign unused_wdata = ^cfg_wdata;

   always_ff @(posedge clk) begin
      if (rst) begin
         en_q  <= 1'b0;
         clr_q <= 1'b0;
         lo_q  <= '0;
         hi_q  <= '1;
      end else if (wr_stb) begin
         case (bwt_reg_e'(cfg_addr))
            REG_CTRL: begin
               clr_q <= cfg_wdata[CTRL_CLR_BIT];
               en_q  <= cfg_wdata[CTRL_EN_BIT];
            end
            REG_LO:  lo_q <= cfg_wdata[ADDR_W-1:0];
            REG_HI:  hi_q <= cfg_wdata[ADDR_W-1:0];
            default: ;
         endcase
      end
   end

   always_comb begin
      rd_mux = '0;
      case (bwt_reg_e'(cfg_addr))
         REG_CTRL: rd_mux[CNT_W-1:0]  = hit_cnt;
         REG_LO:   rd_mux[ADDR_W-1:0] = lo_q;
         REG_HI:   rd_mux[ADDR_W-1:0] = hi_q;
         REG_MISS: rd_mux[CNT_W-1:0]  = miss_cnt;
         default:  rd_mux = '0;
      endcase
   end

   always_ff @(posedge clk) begin
      if (rst) begin
         rdata_q <= '0;
      end else if (rd_stb) begin
         rdata_q <= rd_mux;
      end
   end

   assign cfg_rdata   = rdata_q;
   assign cfg_waitreq = 1'b0;
   assign en          = en_q;
   assign clr         = clr_q;
   assign lo          = lo_q;
   assign hi          = hi_q;

   // R7: a read of the lower bound returns the bound held at the read edge
   a_r7_lo_readback: assert property (@(posedge clk) disable iff (rst)
      (rd_stb && cfg_write_n && cfg_addr == 3'd1) |=> (cfg_rdata[ADDR_W-1:0] == $past(lo_q)));

   // R7: without a read strobe the read data holds
   a_r7_rdata_hold: assert property (@(posedge clk) disable iff (rst)
      !rd_stb |=> $stable(cfg_rdata));

endmodule

// File: rtl/bus_window_tap.sv
module bus_window_tap
   import bwt_pkg::*;
#(
   parameter int ADDR_W   = 32,
   parameter int DATA_W   = 32,
   parameter int BURST_W  = 4,
   parameter int CNT_W    = 32,
   parameter bit SATURATE = 1'b1
) (
   input  logic                clk,
   input  logic                rst,
   input  logic [ADDR_W-1:0]   up_addr,
   input  logic                up_read,
   input  logic                up_write,
   input  logic [DATA_W-1:0]   up_wdata,
   input  logic [DATA_W/8-1:0] up_be,
   input  logic [BURST_W-1:0]  up_burstcnt,
   input  logic                up_burstbegin,
   output logic [DATA_W-1:0]   up_rdata,
   output logic                up_rvalid,
   output logic                up_waitreq,
   output logic [ADDR_W-1:0]   dn_addr,
   output logic                dn_read,
   output logic                dn_write,
   output logic [DATA_W-1:0]   dn_wdata,
   output logic [DATA_W/8-1:0] dn_be,
   output logic [BURST_W-1:0]  dn_burstcnt,
   output logic                dn_burstbegin,
   input  logic [DATA_W-1:0]   dn_rdata,
   input  logic                dn_rvalid,
   input  logic                dn_waitreq,
   input  logic [2:0]          cfg_addr,
   input  logic [DATA_W-1:0]   cfg_wdata,
   input  logic                cfg_write_n,
   input  logic                cfg_read_n,
   output logic [DATA_W-1:0]   cfg_rdata,
   output logic                cfg_waitreq
);

   initial begin
      assert (ADDR_W >= 2 && ADDR_W <= DATA_W)
         else $fatal(1, "bus_window_tap: ADDR_W must fit in DATA_W");
      assert (CNT_W >= 2 && CNT_W <= DATA_W)
         else $fatal(1, "bus_window_tap: CNT_W must fit in DATA_W");
      assert (DATA_W >= 8 && DATA_W % 8 == 0)
         else $fatal(1, "bus_window_tap: DATA_W must be whole bytes");
   end

   logic              accept;
   logic              in_win;
   logic              en_q;
   logic              clr_q;
   logic [ADDR_W-1:0] win_lo;
   logic [ADDR_W-1:0] win_hi;
   logic [CNT_W-1:0]  hit_cnt;
   logic [CNT_W-1:0]  miss_cnt;
   logic              hit_inc;
   logic              miss_inc;

   bwt_passthru #(
      .ADDR_W (ADDR_W),
      .DATA_W (DATA_W),
      .BURST_W(BURST_W)
   ) u_pass (
      .up_addr      (up_addr),
      .up_read      (up_read),
      .up_write     (up_write),
      .up_wdata     (up_wdata),
      .up_be        (up_be),
      .up_burstcnt  (up_burstcnt),
      .up_burstbegin(up_burstbegin),
      .up_rdata     (up_rdata),
      .up_rvalid    (up_rvalid),
      .up_waitreq   (up_waitreq),
      .dn_addr      (dn_addr),
      .dn_read      (dn_read),
      .dn_write     (dn_write),
      .dn_wdata     (dn_wdata),
      .dn_be        (dn_be),
      .dn_burstcnt  (dn_burstcnt),
      .dn_burstbegin(dn_burstbegin),
      .dn_rdata     (dn_rdata),
      .dn_rvalid    (dn_rvalid),
      .dn_waitreq   (dn_waitreq),
      .accept       (accept)
   );

   bwt_window #(.ADDR_W(ADDR_W)) u_win (
      .addr(up_addr),
      .lo  (win_lo),
      .hi  (win_hi),
      .hit (in_win)
   );

   bwt_ctrl #(
      .ADDR_W(ADDR_W),
      .DATA_W(DATA_W),
      .CNT_W (CNT_W)
   ) u_ctrl (
      .clk        (clk),
      .rst        (rst),
      .cfg_addr   (cfg_addr),
      .cfg_wdata  (cfg_wdata),
      .cfg_write_n(cfg_write_n),
      .cfg_read_n (cfg_read_n),
      .cfg_rdata  (cfg_rdata),
      .cfg_waitreq(cfg_waitreq),
      .hit_cnt    (hit_cnt),
      .miss_cnt   (miss_cnt),
      .en         (en_q),
      .clr        (clr_q),
      .lo         (win_lo),
      .hi         (win_hi)
   );

   assign hit_inc  = accept & en_q & in_win;
   assign miss_inc = accept & en_q & ~in_win;

   bwt_sat_counter #(.W(CNT_W), .SATURATE(SATURATE)) u_hit (
      .clk(clk),
      .rst(rst),
      .clr(clr_q),
      .inc(hit_inc),
      .cnt(hit_cnt)
   );

   bwt_sat_counter #(.W(CNT_W), .SATURATE(SATURATE)) u_miss (
      .clk(clk),
      .rst(rst),
      .clr(clr_q),
      .inc(miss_inc),
      .cnt(miss_cnt)
   );

   // R2: a stalled cycle moves neither count
   a_r2_stall_no_count: assert property (@(posedge clk) disable iff (rst)
      (dn_waitreq && !clr_q) |=> ($stable(hit_cnt) && $stable(miss_cnt)));

   // R3: counts freeze while disabled
   a_r3_disabled_hold: assert property (@(posedge clk) disable iff (rst)
      (!en_q && !clr_q) |=> ($stable(hit_cnt) && $stable(miss_cnt)));

   // R6: one transfer lands in one bucket only
   a_r6_single_bucket: assert property (@(posedge clk) disable iff (rst)
      !clr_q |=> !(hit_cnt != $past(hit_cnt) && miss_cnt != $past(miss_cnt)));

   // R1: the request reaches memory in the same cycle
   a_r1_same_cycle: assert property (@(posedge clk) disable iff (rst)
      (up_read || up_write) |-> (dn_read || dn_write));

endmodule

// File: tb/bus_window_tap_tb.sv
module bus_window_tap_tb;

   localparam int PERIOD = 10;
   localparam int AW     = 8;
   localparam int DW     = 32;
   localparam int BW     = 4;
   localparam int CW     = 8;
   localparam int CMAX   = (1 << CW) - 1;

   logic          clk = 1'b0;
   logic          rst = 1'b1;
   logic [AW-1:0] up_addr = '0;
   logic          up_read = 1'b0;
   logic          up_write = 1'b0;
   logic [DW-1:0] up_wdata = '0;
   logic [DW/8-1:0] up_be = '0;
   logic [BW-1:0] up_burstcnt = '0;
   logic          up_burstbegin = 1'b0;
   logic [DW-1:0] up_rdata;
   logic          up_rvalid;
   logic          up_waitreq;
   logic [AW-1:0] dn_addr;
   logic          dn_read;
   logic          dn_write;
   logic [DW-1:0] dn_wdata;
   logic [DW/8-1:0] dn_be;
   logic [BW-1:0] dn_burstcnt;
   logic          dn_burstbegin;
   logic [DW-1:0] dn_rdata = '0;
   logic          dn_rvalid = 1'b0;
   logic          dn_waitreq = 1'b0;
   logic [2:0]    cfg_addr = '0;
   logic [DW-1:0] cfg_wdata = '0;
   logic          cfg_write_n = 1'b1;
   logic          cfg_read_n = 1'b1;
   logic [DW-1:0] cfg_rdata;
   logic          cfg_waitreq;

   int vectors = 0;
   int miscompares = 0;
   int exp_hit = 0;
   int exp_miss = 0;
   int win_lo = 0;
   int win_hi = 255;
   bit en = 1'b0;
   bit done = 1'b0;

   always #(PERIOD/2) clk = ~clk;

   bus_window_tap #(
      .ADDR_W(AW), .DATA_W(DW), .BURST_W(BW), .CNT_W(CW), .SATURATE(1'b1)
   ) u_dut (
      .clk(clk), .rst(rst),
      .up_addr(up_addr), .up_read(up_read), .up_write(up_write),
      .up_wdata(up_wdata), .up_be(up_be), .up_burstcnt(up_burstcnt),
      .up_burstbegin(up_burstbegin), .up_rdata(up_rdata),
      .up_rvalid(up_rvalid), .up_waitreq(up_waitreq),
      .dn_addr(dn_addr), .dn_read(dn_read), .dn_write(dn_write),
      .dn_wdata(dn_wdata), .dn_be(dn_be), .dn_burstcnt(dn_burstcnt),
      .dn_burstbegin(dn_burstbegin), .dn_rdata(dn_rdata),
      .dn_rvalid(dn_rvalid), .dn_waitreq(dn_waitreq),
      .cfg_addr(cfg_addr), .cfg_wdata(cfg_wdata),
      .cfg_write_n(cfg_write_n), .cfg_read_n(cfg_read_n),
      .cfg_rdata(cfg_rdata), .cfg_waitreq(cfg_waitreq)
   );

   task automatic check(input string req, input logic [DW-1:0] act, input logic [DW-1:0] exp);
      vectors++;
      if (act !== exp) begin
         miscompares++;
         $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
      end
   endtask

   task automatic cfg_write(input int a, input logic [DW-1:0] d);
      @(negedge clk);
      cfg_addr    = a[2:0];
      cfg_wdata   = d;
      cfg_write_n = 1'b0;
      @(negedge clk);
      cfg_write_n = 1'b1;
   endtask

   task automatic cfg_read(input int a, output logic [DW-1:0] d);
      @(negedge clk);
      cfg_addr   = a[2:0];
      cfg_read_n = 1'b0;
      @(negedge clk);
      cfg_read_n = 1'b1;
      d = cfg_rdata;
      check("R7 cfg_waitreq low", {31'd0, cfg_waitreq}, 32'd0);
   endtask

   task automatic read_check(input string req, input int a, input int exp);
      logic [DW-1:0] d;
      cfg_read(a, d);
      check(req, d, exp[DW-1:0]);
   endtask

   // One transfer held through 'stall' stalled cycles, then accepted.
   task automatic xfer(input int a, input bit rd, input int stall, input bit pchk);
      @(negedge clk);
      up_addr     = a[AW-1:0];
      up_read     = rd;
      up_write    = ~rd;
      up_wdata    = 32'hC0DE_0000 | a;
      up_be       = a[3:0];
      up_burstcnt = a[BW-1:0];
      up_burstbegin = a[1];
      dn_rdata    = 32'h5A00_0000 | (a << 4);
      dn_rvalid   = a[2];
      for (int s = 0; s < stall; s++) begin
         dn_waitreq = 1'b1;
         #1;
         if (pchk) check("R1 waitreq upstream", {31'd0, up_waitreq}, 32'd1);
         @(negedge clk);
      end
      dn_waitreq = 1'b0;
      #1;
      if (pchk) begin
         check("R1 addr downstream", {24'd0, dn_addr}, a);
         check("R1 strobes downstream", {30'd0, dn_read, dn_write}, {30'd0, rd, ~rd});
         check("R1 wdata downstream", dn_wdata, 32'hC0DE_0000 | a);
         check("R1 be/burst downstream", {23'd0, dn_burstbegin, dn_burstcnt, dn_be},
               {23'd0, a[1], a[BW-1:0], a[3:0]});
         check("R1 rdata upstream", up_rdata, 32'h5A00_0000 | (a << 4));
         check("R1 rvalid/waitreq upstream", {30'd0, up_rvalid, up_waitreq}, {30'd0, a[2], 1'b0});
      end
      @(negedge clk);
      up_read  = 1'b0;
      up_write = 1'b0;
      if (en) begin
         if (a >= win_lo && a <= win_hi) begin
            if (exp_hit < CMAX) exp_hit++;
         end else begin
            if (exp_miss < CMAX) exp_miss++;
         end
      end
   endtask

   task automatic set_window(input int lo, input int hi);
      cfg_write(1, lo);
      cfg_write(2, hi);
      win_lo = lo;
      win_hi = hi;
   endtask

   task automatic clear_and_run(input bit enable);
      cfg_write(0, {30'd0, enable, 1'b1});
      cfg_write(0, {30'd0, enable, 1'b0});
      en = enable;
      exp_hit  = 0;
      exp_miss = 0;
   endtask

   initial begin
      #(PERIOD * 200000);
      if (!done) begin
         miscompares++;
         vectors++;
         $display("FAIL watchdog expired");
         $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
         $finish;
      end
   end

   initial begin
      logic [DW-1:0] d;
      repeat (4) @(negedge clk);
      rst = 1'b0;

      // R9 reset state
      read_check("R9 reset hit count", 0, 0);
      read_check("R9 reset lower bound", 1, 0);
      read_check("R9 reset upper bound", 2, 255);
      read_check("R9 reset miss count", 3, 0);

      // R3 disabled after reset: traffic not counted
      for (int i = 0; i < 6; i++) xfer(i * 37, i[0], i % 3, 1'b1);
      read_check("R3 disabled hit count", 0, 0);
      read_check("R3 disabled miss count", 3, 0);

      // R5/R6/R2 exhaustive address sweep with stalls
      set_window(40, 200);
      read_check("R7 lower bound readback", 1, 40);
      read_check("R7 upper bound readback", 2, 200);
      clear_and_run(1'b1);
      for (int a = 0; a < 256; a++) begin
         xfer(a, a[0], a % 3, (a % 5) == 0);
         if ((a % 16) == 15) begin
            read_check("R5 sweep hit count", 0, exp_hit);
            read_check("R6 sweep miss count", 3, exp_miss);
         end
      end
      read_check("R5 total hits", 0, 161);
      read_check("R6 total misses", 3, 95);

      // R5 exact bounds
      clear_and_run(1'b1);
      xfer(39, 1'b1, 0, 1'b0);
      xfer(40, 1'b0, 1, 1'b0);
      xfer(200, 1'b1, 2, 1'b0);
      xfer(201, 1'b0, 0, 1'b0);
      read_check("R5 bound hits", 0, 2);
      read_check("R6 bound misses", 3, 2);

      // R2 long stall counts once
      xfer(100, 1'b1, 7, 1'b0);
      read_check("R2 long stall single count", 0, 3);

      // R4 clear held: accepted transfers do not count
      cfg_write(0, 32'h3);
      xfer(50, 1'b1, 0, 1'b0);
      xfer(10, 1'b0, 0, 1'b0);
      read_check("R4 held clear hits", 0, 0);
      read_check("R4 held clear misses", 3, 0);
      cfg_write(0, 32'h2);
      exp_hit = 0;
      exp_miss = 0;
      for (int i = 0; i < 3; i++) xfer(60 + i, 1'b1, 0, 1'b0);
      read_check("R4 count after release", 0, 3);

      // R3 disable freezes counts
      cfg_write(0, 32'h0);
      en = 1'b0;
      for (int i = 0; i < 4; i++) xfer(70 + i, 1'b0, 1, 1'b0);
      xfer(5, 1'b0, 0, 1'b0);
      read_check("R3 frozen hits", 0, 3);
      read_check("R3 frozen misses", 3, 0);

      // R6 inverted window: all misses
      set_window(100, 50);
      clear_and_run(1'b1);
      xfer(75, 1'b1, 0, 1'b0);
      xfer(100, 1'b1, 0, 1'b0);
      xfer(50, 1'b0, 1, 1'b0);
      read_check("R6 empty window hits", 0, 0);
      read_check("R6 empty window misses", 3, 3);

      // R8 saturation
      set_window(0, 255);
      clear_and_run(1'b1);
      for (int i = 0; i < 260; i++) xfer(i % 256, i[0], 0, 1'b0);
      read_check("R8 saturated hits", 0, CMAX);
      read_check("R8 miss untouched", 3, 0);
      xfer(3, 1'b1, 0, 1'b0);
      read_check("R8 still saturated", 0, CMAX);

      // R7 unused words read zero
      for (int w = 4; w < 8; w++) read_check("R7 unused word zero", w, 0);
      cfg_read(1, d);
      check("R7 full lower bound", d, 0);

      done = 1'b1;
      $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
      $finish;
   end

endmodule